// File: doc/BRIEF.md
# DRAM Request Scheduler

This block sits between the front-end of a DRAM controller and its command back-end. Requests arrive already split into bank, row and column, together with a read/write flag and a tag. They wait in a small queue. On every cycle the scheduler offers exactly one of the queued requests to the back-end.

To choose that request, it ranks the candidates. The block keeps a table of the row that is open in each bank, which the back-end updates through a feedback port. It also remembers the direction of the last request it handed over. A request that hits an open row ranks highest. Among the rest, a request that keeps the data bus in the same direction ranks next. Reads are preferred after that, and the oldest request wins any remaining tie.

Two rules can override the ranking:
- A request never overtakes an older request to the same address when either of the two is a write.
- The oldest request is forced through once it has been passed over too often.

The choice is made again on every cycle from the current queue and table contents.

Top module: `dram_req_sched`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. Every bank is marked closed, and no previous direction is recorded.
- R2: Among eligible requests, one whose row equals the open row of its bank is always chosen over one that misses.
- R3: When hit status is equal, a request whose `wr` bit equals that of the last request accepted at the output (`out_valid && out_ready`) is chosen over one that differs.
- R4: When hit and direction-match status are equal, a read (`wr`=0) is chosen over a write. With a recorded direction these tiers coincide, so this rule decides only while no direction has been recorded since reset.
- R5: Remaining ties go to the request that entered the queue earliest.
- R6: The queue holds 8 requests. `in_ready` is 0 while 8 are held, and a request offered then is dropped and never appears at the output.
- R7: A feedback write with `fb_open`=1 marks bank `fb_bank` open at row `fb_row`. A feedback write with `fb_open`=0 marks that bank closed. Each bank is tracked separately, and a change takes effect from the next cycle.
- R8: A request is not eligible while an older queued request has the same bank, row and column and either of the two is a write.
- R9: Count the selections accepted while the oldest request stays queued. Once that count reaches 32, the oldest request is the one offered, whatever its rank. The count restarts whenever the oldest entry leaves.
- R10: `out_valid` is 1 whenever the queue is not empty. The `out_*` fields carry the chosen request, and an accepted output removes that request from the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Queue has room |
| in_wr | input | 1 | 1 = write, 0 = read |
| in_bank | input | 3 | Bank |
| in_row | input | 14 | Row |
| in_col | input | 10 | Column |
| in_tag | input | 4 | Request tag |
| out_valid | output | 1 | A request is offered |
| out_ready | input | 1 | Back-end takes the offered request |
| out_wr | output | 1 | Chosen request direction |
| out_bank | output | 3 | Chosen request bank |
| out_row | output | 14 | Chosen request row |
| out_col | output | 10 | Chosen request column |
| out_tag | output | 4 | Chosen request tag |
| fb_we | input | 1 | Open-row feedback write |
| fb_open | input | 1 | 1 = row opened, 0 = bank closed |
| fb_bank | input | 3 | Bank being updated |
| fb_row | input | 14 | Row now open |

## Verification
The forced pick of the oldest request is the hardest state to reach. The oldest entry must lose 32 accepted selections in a row while never leaving the queue. The bench parks a poorly ranked write (a miss, in the wrong direction) at the head of the queue. It then feeds one younger hitting read at a time and accepts it, checking the chosen tag on every round. Rounds 31 and 32 straddle the threshold, so an off-by-one in the counter shows up.

// File: rtl/dsched_pkg.sv
package dsched_pkg;
  localparam int BANK_W = 3;
  localparam int NBANK  = 1 << BANK_W;
  localparam int ROW_W  = 14;
  localparam int COL_W  = 10;
  localparam int TAG_W  = 4;

  typedef struct packed {
    logic             wr;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [TAG_W-1:0]  tag;
  } req_t;

  // rank vector: higher wins; bit order sets the priority tiers
  function automatic logic [2:0] rank_of(input logic hit, input logic same_dir,
                                         input logic is_rd);
    return {hit, same_dir, is_rd};
  endfunction

  function automatic logic same_addr(input req_t a, input req_t b);
    return (a.bank == b.bank) && (a.row == b.row) && (a.col == b.col);
  endfunction

  // younger may not pass older when addresses match and a write is involved
  function automatic logic hazard(input req_t older, input req_t younger);
    return same_addr(older, younger) && (older.wr || younger.wr);
  endfunction
endpackage

// File: rtl/bank_row_table.sv
module bank_row_table
  import dsched_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              upd_open,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row,
  output logic [NBANK-1:0]  open_vld,
  output logic [ROW_W-1:0]  open_row [NBANK]
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_vld[b] <= 1'b0;
        open_row[b] <= '0;
      end else if (upd && (upd_bank == BANK_W'(b))) begin
        open_vld[b] <= upd_open;
        if (upd_open) open_row[b] <= upd_row;
      end
    end
  end

  // R7: an open update is visible in the addressed bank next cycle
  a_r7_open_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && upd_open) |=> (open_vld[$past(upd_bank)] &&
                           open_row[$past(upd_bank)] == $past(upd_row)));
  a_r7_close_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !upd_open) |=> !open_vld[$past(upd_bank)]);
endmodule

// File: rtl/sched_queue.sv
module sched_queue
  import dsched_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  req_t          push_req,
  input  logic          pop,
  input  logic [IW-1:0] pop_idx,
  output req_t          ent [DEPTH],
  output logic [DEPTH-1:0] vld,
  output logic [CW-1:0] count
);
  req_t          q_r [DEPTH];
  req_t          q_n [DEPTH];
  logic [CW-1:0] cnt_r, cnt_n;

  // entries stay compacted: index 0 is always the oldest
  always_comb begin
    for (int i = 0; i < DEPTH; i++) q_n[i] = q_r[i];
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++)
        if (i >= int'(pop_idx)) q_n[i] = q_r[i+1];
    end
    for (int i = 0; i < DEPTH; i++)
      if (push && (i == int'(cnt_r) - int'(pop))) q_n[i] = push_req;
    cnt_n = cnt_r + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_r <= '0;
    else        cnt_r <= cnt_n;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) q_r[i] <= q_n[i];
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent[i] = q_r[i];
      vld[i] = (i < int'(cnt_r));
    end
  end
  assign count = cnt_r;

  // R6: occupancy never passes the depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_r <= CW'(DEPTH));
  // R6: a full queue stays full until something leaves
  a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_r == CW'(DEPTH) && !pop) |=> (cnt_r == CW'(DEPTH)));
  // R10: a pop always names a held entry
  a_r10_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (int'(pop_idx) < int'(cnt_r)));
endmodule

// File: rtl/sched_pick.sv
module sched_pick
  import dsched_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  req_t             ent [DEPTH],
  input  logic [DEPTH-1:0] vld,
  input  logic [NBANK-1:0] open_vld,
  input  logic [ROW_W-1:0] open_row [NBANK],
  input  logic             last_vld,
  input  logic             last_wr,
  input  logic             force_old,
  output logic [IW-1:0]    sel_idx,
  output logic             sel_any,
  output logic [DEPTH-1:0] hit_vec,
  output logic [DEPTH-1:0] blk_vec
);
  logic [2:0]    rank, best_rank;
  logic [IW-1:0] best;
  logic          found;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit_vec[i] = vld[i] && open_vld[ent[i].bank] &&
                   (open_row[ent[i].bank] == ent[i].row);
      blk_vec[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (j < i && vld[j] && hazard(ent[j], ent[i])) blk_vec[i] = 1'b1;
    end
  end

  always_comb begin
    found     = 1'b0;
    best_rank = '0;
    best      = '0;
    rank      = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && !blk_vec[i]) begin
        rank = rank_of(hit_vec[i], last_vld && (ent[i].wr == last_wr), !ent[i].wr);
        if (!found || rank > best_rank) begin
          found     = 1'b1;
          best_rank = rank;
          best      = IW'(i);
        end
      end
    end
    sel_any = found;
    sel_idx = (force_old && vld[0]) ? '0 : best;
  end

  // R2: if any eligible hit exists and no forcing applies, a hit is chosen
  a_r2_hit_first: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_any && !force_old && |(hit_vec & ~blk_vec)) |-> hit_vec[sel_idx]);
  // R8: the chosen entry never passes an older conflicting entry
  a_r8_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    sel_any |-> !blk_vec[sel_idx]);
  // R8: the oldest entry is never blocked
  a_r8_head_free: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_vec[0]);
endmodule

// File: rtl/dram_req_sched.sv
module dram_req_sched
  import dsched_pkg::*;
#(
  parameter  int DEPTH     = 8,
  parameter  int AGE_LIMIT = 32,
  localparam int IW        = $clog2(DEPTH),
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int AW        = $clog2(AGE_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_wr,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [COL_W-1:0]  in_col,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_wr,
  output logic [BANK_W-1:0] out_bank,
  output logic [ROW_W-1:0]  out_row,
  output logic [COL_W-1:0]  out_col,
  output logic [TAG_W-1:0]  out_tag,
  input  logic              fb_we,
  input  logic              fb_open,
  input  logic [BANK_W-1:0] fb_bank,
  input  logic [ROW_W-1:0]  fb_row
);
  req_t             ent [DEPTH];
  logic [DEPTH-1:0] vld, hit_vec, blk_vec;
  logic [CW-1:0]    count;
  logic [NBANK-1:0] open_vld;
  logic [ROW_W-1:0] open_row [NBANK];
  logic [IW-1:0]    sel_idx;
  logic             sel_any, fire_in, fire_out, force_old;
  logic             last_vld, last_wr;
  logic [AW-1:0]    age;
  req_t             in_req, sel_req;

  assign in_req   = '{wr: in_wr, bank: in_bank, row: in_row, col: in_col, tag: in_tag};
  assign in_ready = (count < CW'(DEPTH));
  assign fire_in  = in_valid && in_ready;
  assign fire_out = out_valid && out_ready;

  sched_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(fire_in), .push_req(in_req),
    .pop(fire_out), .pop_idx(sel_idx), .ent(ent), .vld(vld), .count(count));

  bank_row_table u_rows (
    .clk(clk), .rst_n(rst_n), .upd(fb_we), .upd_open(fb_open),
    .upd_bank(fb_bank), .upd_row(fb_row), .open_vld(open_vld), .open_row(open_row));

  sched_pick #(.DEPTH(DEPTH)) u_pick (
    .clk(clk), .rst_n(rst_n), .ent(ent), .vld(vld), .open_vld(open_vld),
    .open_row(open_row), .last_vld(last_vld), .last_wr(last_wr),
    .force_old(force_old), .sel_idx(sel_idx), .sel_any(sel_any),
    .hit_vec(hit_vec), .blk_vec(blk_vec));

  assign sel_req   = ent[sel_idx];
  assign out_valid = sel_any;
  assign out_wr    = sel_req.wr;
  assign out_bank  = sel_req.bank;
  assign out_row   = sel_req.row;
  assign out_col   = sel_req.col;
  assign out_tag   = sel_req.tag;

  // counts accepted selections that passed over the head entry
  assign force_old = (age >= AW'(AGE_LIMIT));
  always_ff @(posedge clk) begin
    if (!rst_n)                 age <= '0;
    else if (fire_out) begin
      if (sel_idx == '0)        age <= '0;
      else if (!force_old)      age <= age + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_vld <= 1'b0;
      last_wr  <= 1'b0;
    end else if (fire_out) begin
      last_vld <= 1'b1;
      last_wr  <= sel_req.wr;
    end
  end

  // R9: the pass-over count is bounded by the limit
  a_r9_age_bound: assert property (@(posedge clk) disable iff (!rst_n)
    age <= AW'(AGE_LIMIT));
  // R9: once forced, the accepted request is the head and the count restarts
  a_r9_forced_head: assert property (@(posedge clk) disable iff (!rst_n)
    (force_old && fire_out) |=> (age == '0));
  // R10: output valid tracks a non-empty queue
  a_r10_valid_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (count != '0));
  // R3: last direction is recorded after every accepted output
  a_r3_dir_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    fire_out |=> (last_vld && last_wr == $past(out_wr)));
endmodule

// File: tb/dram_req_sched_bench.sv
module dram_req_sched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_wr = 1'b0;
  logic [2:0]  in_bank = '0;
  logic [13:0] in_row = '0;
  logic [9:0]  in_col = '0;
  logic [3:0]  in_tag = '0;
  logic        in_ready, out_valid, out_wr;
  logic        out_ready = 1'b0;
  logic [2:0]  out_bank;
  logic [13:0] out_row;
  logic [9:0]  out_col;
  logic [3:0]  out_tag;
  logic        fb_we = 1'b0, fb_open = 1'b0;
  logic [2:0]  fb_bank = '0;
  logic [13:0] fb_row = '0;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  dram_req_sched u_dram_req_sched (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_wr(in_wr), .in_bank(in_bank), .in_row(in_row), .in_col(in_col),
    .in_tag(in_tag), .out_valid(out_valid), .out_ready(out_ready),
    .out_wr(out_wr), .out_bank(out_bank), .out_row(out_row), .out_col(out_col),
    .out_tag(out_tag), .fb_we(fb_we), .fb_open(fb_open), .fb_bank(fb_bank),
    .fb_row(fb_row));

  // pw: prime direction; ob/orow: bank opened; A then B pushed; ex: expected tag
  typedef struct packed {
    int pw; int ob; int orow;
    int awr; int abank; int arow; int acol;
    int bwr; int bbank; int brow; int bcol;
    int ex; int exbank;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{0, 2, 9, 0, 1, 5, 0, 0, 2, 9, 1, 2, 2},  // R2 hit beats older miss
    '{1, 0, 0, 0, 1, 1, 0, 1, 3, 2, 0, 2, 3},  // R3 write after write beats read
    '{0, 0, 0, 1, 1, 1, 0, 0, 3, 2, 0, 2, 3},  // R3 read after read
    '{1, 0, 0, 1, 1, 1, 0, 1, 3, 2, 0, 1, 1},  // R5 full tie -> oldest
    '{1, 4, 3, 1, 1, 1, 0, 0, 4, 3, 0, 2, 4},  // R2 hit over direction
    '{0, 1, 6, 1, 1, 2, 8, 0, 1, 2, 8, 1, 1},  // R8 read held behind write
    '{1, 7, 0, 0, 5, 2, 3, 1, 5, 2, 3, 1, 5},  // R8 write held behind read
    '{0, 5, 2, 0, 1, 1, 0, 1, 5, 2, 4, 2, 5}   // R2 hit over direction and read
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input int wr, input int bank, input int row, input int col,
                      input int tag);
    @(negedge clk);
    in_valid = 1'b1; in_wr = wr[0]; in_bank = 3'(bank);
    in_row = 14'(row); in_col = 10'(col); in_tag = 4'(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic feedback(input int bank, input int row, input int open);
    @(negedge clk);
    fb_we = 1'b1; fb_bank = 3'(bank); fb_row = 14'(row); fb_open = open[0];
    @(negedge clk);
    fb_we = 1'b0;
  endtask

  task automatic take_one();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic drain();
    if (out_valid) begin
      out_ready = 1'b1;
      do @(negedge clk); while (out_valid);
      out_ready = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);

    // R4 no direction recorded yet: read beats older write
    push(1, 1, 1, 0, 1);
    push(0, 3, 2, 0, 2);
    chk(out_tag == 4'd2, "R4 read preferred", int'(out_tag), 2);
    drain();

    // table of ranking vectors
    for (int v = 0; v < 8; v++) begin
      feedback(VEC[v].ob, VEC[v].orow, 1);
      push(VEC[v].pw, 0, 0, 0, 0);
      take_one();
      push(VEC[v].awr, VEC[v].abank, VEC[v].arow, VEC[v].acol, 1);
      push(VEC[v].bwr, VEC[v].bbank, VEC[v].brow, VEC[v].bcol, 2);
      chk(out_tag == 4'(VEC[v].ex), $sformatf("R2/R3/R5/R8 vec %0d tag", v),
          int'(out_tag), VEC[v].ex);
      chk(out_bank == 3'(VEC[v].exbank), $sformatf("R10 vec %0d bank", v),
          int'(out_bank), VEC[v].exbank);
      drain();
      feedback(VEC[v].ob, 0, 0);
    end

    // R7 per-bank close removes the hit
    feedback(6, 4, 1);
    push(0, 1, 1, 0, 1);
    push(0, 6, 4, 0, 2);
    chk(out_tag == 4'd2, "R7 open row hit", int'(out_tag), 2);
    feedback(6, 0, 0);
    chk(out_tag == 4'd1, "R7 closed bank", int'(out_tag), 1);
    drain();

    // R6 full queue and dropped request
    for (int k = 0; k < 8; k++) push(0, 0, 0, k, k);
    chk(in_ready == 1'b0, "R6 full ready low", int'(in_ready), 0);
    push(0, 7, 7, 7, 9);
    begin
      int seen = 0;
      int bad  = 0;
      out_ready = 1'b1;
      while (out_valid) begin
        if (out_tag == 4'd9) bad++;
        seen++;
        @(negedge clk);
      end
      out_ready = 1'b0;
      chk(seen == 8, "R6 eight held", seen, 8);
      chk(bad == 0, "R6 dropped never out", bad, 0);
    end
    chk(out_valid == 1'b0, "R10 empty after drain", int'(out_valid), 0);

    // R9 starvation: head write misses and loses direction to hitting reads
    feedback(2, 5, 1);
    push(0, 0, 0, 0, 0);
    take_one();
    push(1, 0, 1, 0, 15);
    for (int it = 0; it <= 32; it++) begin
      push(0, 2, 5, it, 3);
      chk(out_tag == ((it < 32) ? 4'd3 : 4'd15), $sformatf("R9 round %0d", it),
          int'(out_tag), (it < 32) ? 3 : 15);
      take_one();
    end
    chk(out_tag == 4'd3, "R9 hit left after forced pick", int'(out_tag), 3);
    drain();

    finish_run();
  end
endmodule